// File: doc/BRIEF.md
# TDM Serial Bit Engine with Frame-Sync Checking

This block runs one time-division-multiplexed serial link. It watches an external bit clock and a frame-sync input, both sampled in a faster engine clock domain. It shifts 8-bit timeslots out on a serial data pin and in from another. A configuration bit chooses whether each byte travels most-significant bit first or least-significant bit first. Within every bit period, two programmed counts of the engine clock set when received data is sampled and when the output driver lets go after the final bit of a slot. A per-slot transmit mask decides which slots the engine drives at all.

The engine keeps its own frame position: slot number, bit within the slot, and an optional single extra bit after the last slot. Once enabled, it hunts for a first frame sync. From then on it requires frame sync to appear at the frame start and nowhere else. Any departure from that rule stops the engine. The engine then releases the pins, stops transmit and receive work, and keeps the position at which the fault was seen so software can read it. Byte-level strobes connect it to the transmit and receive buffers: one strobe for each byte taken and one for each byte assembled.

Top module: `tdm_serial_engine`

## Requirements
- R1: After reset, `link_active`, `sd_oe`, `halted`, `err_missed`, `err_extra` and `rx_valid` are all 0.
- R2: When `enable` rises, the engine hunts and does not drive. The first detected rising edge of `bclk` with the selected frame sync at 1 makes that bit period slot 0, bit 0.
- R3: Position rules:
  - The position advances once per detected rising `bclk` edge, and the new value shows on `cur_slot`/`cur_bit`/`cur_extra` from the engine cycle after that edge.
  - Bits run 0..7 within a slot, and slots run 0..`num_slots`-1.
  - When `extra_bit`=1, one extra bit period follows the last slot, reported as `cur_slot`=last slot, `cur_bit`=0, `cur_extra`=1.
  - The position then wraps to slot 0, bit 0.
- R4: Transmit data and timing:
  - In a driven slot, the byte on `tx_data` is taken at bit 0, and `tx_take` pulses for one cycle.
  - `sd_out` carries byte bit `7-b` for bit `b` when `lsb_first`=0, and byte bit `b` when `lsb_first`=1.
  - New drive values appear two engine cycles after the rising `bclk` sample.
- R5: `sd_oe` is 1 only in slots whose `tx_mask` bit (indexed by slot number) is 1. It is never 1 in the extra bit.
- R6: Drive release:
  - On bit 7 of a driven slot whose successor is not driven, `sd_oe` falls after the engine edge at which the count since the bit start equals `drv_stop`. The count is 0 in the first engine cycle after the rising-edge sample.
  - If the successor slot is driven, `sd_oe` stays 1.
- R7: `sd_in` is sampled at the engine edge at which the same count equals `samp_pt`. No sampling happens in the extra bit.
- R8: After the eighth sample of a slot, `rx_valid` pulses for one cycle with the assembled byte on `rx_data` and the slot number on `rx_slot`. The bit order follows the same `lsb_first` rule as R4.
- R9: `sync_sel`=0 follows `fsync0` and `sync_sel`=1 follows `fsync1`. The unselected input has no effect.
- R10: If frame sync is 0 at a rising `bclk` edge that starts slot 0 bit 0, the engine halts with `err_missed`=1 and the position frozen at slot 0, bit 0.
- R11: If frame sync is 1 at any other rising `bclk` edge while running, the engine halts with `err_extra`=1 and the position frozen at the offending bit.
- R12: While halted:
  - `sd_oe`, `rx_valid` and `link_active` are 0, and the position does not change on further `bclk` edges.
  - The halt and the error flags hold until `enable` goes low.
- R13: With `enable` low, `link_active` and `sd_oe` are 0 from the next engine cycle. This releases the serial pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Engine enable; low returns to idle and clears a halt |
| lsb_first | input | 1 | 1 selects least-significant-bit-first shifting |
| sync_sel | input | 1 | Selects `fsync1` (1) or `fsync0` (0) |
| num_slots | input | SW+1 | Slots per frame, 1..MAX_SLOTS |
| extra_bit | input | 1 | Adds one bit period after the last slot |
| samp_pt | input | CW | Engine counts from bit start to the receive sample |
| drv_stop | input | CW | Engine counts from bit start to the drive release on a slot's last bit |
| tx_mask | input | MAX_SLOTS | One bit per slot, 1 = drive the slot |
| bclk | input | 1 | Serial bit clock |
| fsync0 | input | 1 | Frame sync line 0 |
| fsync1 | input | 1 | Frame sync line 1 |
| sd_in | input | 1 | Serial receive data |
| tx_data | input | 8 | Next transmit byte from the buffer |
| sd_out | output | 1 | Serial transmit data |
| sd_oe | output | 1 | Output enable for `sd_out` |
| link_active | output | 1 | Engine owns the serial pins (hunting or running) |
| tx_take | output | 1 | One-cycle strobe: `tx_data` was taken |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a received byte |
| rx_data | output | 8 | Received byte |
| rx_slot | output | SW | Slot of the received byte |
| halted | output | 1 | Engine stopped on a framing error |
| err_missed | output | 1 | Frame sync absent at frame start |
| err_extra | output | 1 | Frame sync seen away from frame start |
| cur_slot | output | SW | Current (or frozen) slot |
| cur_bit | output | 3 | Current (or frozen) bit within slot |
| cur_extra | output | 1 | Current position is the extra bit |

## Verification
A corrupted frame position has two possible effects. It shows within one bit period on `cur_slot`/`cur_bit`. Within one frame, it turns into a false `err_missed` or `err_extra` halt, because the frame-start check depends on the position counter. A wrong engine-clock count or bit-start strobe moves the `sd_oe` release edge or the `sd_in` capture cycle. Either fault corrupts `rx_data` or the `sd_oe` waveform within the same bit period. A stale transmit shift register or a bad mask lookup shows as a wrong `sd_out` or `sd_oe` on the next driven bit.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int SLOT_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_RUN  = 2'd2,
        ST_HALT = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic missed;
        logic extra;
    } sync_err_t;

    // Bit of a slot byte that travels in bit period idx of that slot.
    function automatic logic slot_bit(input logic [SLOT_BITS-1:0] b,
                                      input logic [2:0] idx,
                                      input logic lsb);
        return lsb ? b[idx] : b[3'd7 - idx];
    endfunction

endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          armed,
    input  logic          bclk,
    output logic          rise,
    output logic [CW-1:0] ecnt
);
    logic bclk_q;

    assign rise = armed & bclk & ~bclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            ecnt   <= '0;
        end else begin
            bclk_q <= bclk;
            if (rise)
                ecnt <= '0;
            else if (ecnt != '1)
                ecnt <= ecnt + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker
    import tdm_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int SW = $clog2(MAX_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          rise,
    input  logic          fs,
    input  logic [SW:0]   num_slots,
    input  logic          extra_en,
    output eng_state_e    state,
    output logic [SW-1:0] slot,
    output logic [2:0]    bit_idx,
    output logic          xtra,
    output logic [SW-1:0] nx_slot,
    output logic          nx_extra,
    output logic          bit_start,
    output sync_err_t     err
);
    logic [SW:0]   last_wide;
    logic [SW-1:0] last_slot;
    logic [2:0]    nx_bit;
    logic          wrap;

    assign last_wide = num_slots - 1'b1;
    assign last_slot = last_wide[SW-1:0];

    always_comb begin
        nx_slot  = slot;
        nx_bit   = bit_idx + 3'd1;
        nx_extra = 1'b0;
        if (xtra) begin
            nx_slot = '0;
            nx_bit  = 3'd0;
        end else if (bit_idx == 3'd7) begin
            if (slot == last_slot) begin
                if (extra_en) nx_extra = 1'b1;
                else          nx_slot  = '0;
            end else begin
                nx_slot = slot + 1'b1;
            end
        end
    end

    assign wrap = (nx_slot == '0) && (nx_bit == 3'd0) && !nx_extra;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            slot      <= '0;
            bit_idx   <= 3'd0;
            xtra      <= 1'b0;
            bit_start <= 1'b0;
            err       <= '0;
        end else begin
            bit_start <= 1'b0;
            unique case (state)
                ST_IDLE: if (enable) begin
                    state   <= ST_HUNT;
                    err     <= '0;
                    slot    <= '0;
                    bit_idx <= 3'd0;
                    xtra    <= 1'b0;
                end
                ST_HUNT: if (!enable) begin
                    state <= ST_IDLE;
                end else if (rise && fs) begin
                    state     <= ST_RUN;
                    bit_start <= 1'b1;
                end
                ST_RUN: if (!enable) begin
                    state <= ST_IDLE;
                end else if (rise) begin
                    slot    <= nx_slot;
                    bit_idx <= nx_bit;
                    xtra    <= nx_extra;
                    if (wrap != fs) begin
                        state      <= ST_HALT;
                        err.missed <= wrap;
                        err.extra  <= !wrap;
                    end else begin
                        bit_start <= 1'b1;
                    end
                end
                ST_HALT: if (!enable) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
    import tdm_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int SW = $clog2(MAX_SLOTS),
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 running,
    input  logic                 bit_start,
    input  logic [SW-1:0]        slot,
    input  logic [2:0]           bit_idx,
    input  logic                 xtra,
    input  logic [SW-1:0]        nx_slot,
    input  logic                 nx_extra,
    input  logic [MAX_SLOTS-1:0] tx_mask,
    input  logic [SLOT_BITS-1:0] tx_data,
    input  logic                 lsb_first,
    input  logic [CW-1:0]        ecnt,
    input  logic [CW-1:0]        drv_stop,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 tx_take
);
    logic [SLOT_BITS-1:0] tx_sh;
    logic                 oe_r;
    logic                 cur_drv, nxt_drv, stop_hit;

    assign cur_drv  = tx_mask[slot] & ~xtra;
    assign nxt_drv  = tx_mask[nx_slot] & ~nx_extra;
    assign stop_hit = (bit_idx == 3'd7) & ~xtra & ~nxt_drv & (ecnt == drv_stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            sd_out  <= 1'b0;
            oe_r    <= 1'b0;
            tx_take <= 1'b0;
        end else begin
            tx_take <= 1'b0;
            if (!running) begin
                oe_r <= 1'b0;
            end else if (bit_start) begin
                oe_r <= cur_drv & ~stop_hit;
                if (cur_drv) begin
                    if (bit_idx == 3'd0) begin
                        tx_sh   <= tx_data;
                        sd_out  <= slot_bit(tx_data, bit_idx, lsb_first);
                        tx_take <= 1'b1;
                    end else begin
                        sd_out <= slot_bit(tx_sh, bit_idx, lsb_first);
                    end
                end
            end else if (stop_hit) begin
                oe_r <= 1'b0;
            end
        end
    end

    assign sd_oe = oe_r & running;
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
    import tdm_pkg::*;
#(
    parameter int SW = 3,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 running,
    input  logic [SW-1:0]        slot,
    input  logic [2:0]           bit_idx,
    input  logic                 xtra,
    input  logic [CW-1:0]        ecnt,
    input  logic [CW-1:0]        samp_pt,
    input  logic                 sd_in,
    input  logic                 lsb_first,
    output logic                 rx_valid,
    output logic [SLOT_BITS-1:0] rx_data,
    output logic [SW-1:0]        rx_slot
);
    logic [SLOT_BITS-1:0] rx_sh, assembled;
    logic                 hit;

    assign hit       = running & ~xtra & (ecnt == samp_pt);
    assign assembled = lsb_first ? {sd_in, rx_sh[SLOT_BITS-1:1]}
                                 : {rx_sh[SLOT_BITS-2:0], sd_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_slot  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (hit) begin
                rx_sh <= assembled;
                if (bit_idx == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_data  <= assembled;
                    rx_slot  <= slot;
                end
            end
        end
    end
endmodule

// File: rtl/tdm_serial_engine.sv
module tdm_serial_engine
    import tdm_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    parameter int CW = 16,
    localparam int SW = $clog2(MAX_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 lsb_first,
    input  logic                 sync_sel,
    input  logic [SW:0]          num_slots,
    input  logic                 extra_bit,
    input  logic [CW-1:0]        samp_pt,
    input  logic [CW-1:0]        drv_stop,
    input  logic [MAX_SLOTS-1:0] tx_mask,
    input  logic                 bclk,
    input  logic                 fsync0,
    input  logic                 fsync1,
    input  logic                 sd_in,
    input  logic [7:0]           tx_data,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 link_active,
    output logic                 tx_take,
    output logic                 rx_valid,
    output logic [7:0]           rx_data,
    output logic [SW-1:0]        rx_slot,
    output logic                 halted,
    output logic                 err_missed,
    output logic                 err_extra,
    output logic [SW-1:0]        cur_slot,
    output logic [2:0]           cur_bit,
    output logic                 cur_extra
);
    eng_state_e    state;
    sync_err_t     err;
    logic          rise, fs, running, bit_start;
    logic [CW-1:0] ecnt;
    logic [SW-1:0] nx_slot;
    logic          nx_extra;

    assign fs          = sync_sel ? fsync1 : fsync0;
    assign running     = (state == ST_RUN);
    assign link_active = (state == ST_RUN) || (state == ST_HUNT);
    assign halted      = (state == ST_HALT);
    assign err_missed  = err.missed;
    assign err_extra   = err.extra;

    tdm_bit_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .armed(link_active), .bclk(bclk),
        .rise(rise), .ecnt(ecnt)
    );

    tdm_frame_tracker #(.MAX_SLOTS(MAX_SLOTS), .SW(SW)) u_frame (
        .clk(clk), .rst(rst), .enable(enable), .rise(rise), .fs(fs),
        .num_slots(num_slots), .extra_en(extra_bit), .state(state),
        .slot(cur_slot), .bit_idx(cur_bit), .xtra(cur_extra),
        .nx_slot(nx_slot), .nx_extra(nx_extra), .bit_start(bit_start),
        .err(err)
    );

    tdm_tx_lane #(.MAX_SLOTS(MAX_SLOTS), .SW(SW), .CW(CW)) u_tx (
        .clk(clk), .rst(rst), .running(running), .bit_start(bit_start),
        .slot(cur_slot), .bit_idx(cur_bit), .xtra(cur_extra),
        .nx_slot(nx_slot), .nx_extra(nx_extra), .tx_mask(tx_mask),
        .tx_data(tx_data), .lsb_first(lsb_first), .ecnt(ecnt),
        .drv_stop(drv_stop), .sd_out(sd_out), .sd_oe(sd_oe), .tx_take(tx_take)
    );

    tdm_rx_lane #(.SW(SW), .CW(CW)) u_rx (
        .clk(clk), .rst(rst), .running(running), .slot(cur_slot),
        .bit_idx(cur_bit), .xtra(cur_extra), .ecnt(ecnt), .samp_pt(samp_pt),
        .sd_in(sd_in), .lsb_first(lsb_first), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_slot(rx_slot)
    );
endmodule

// File: rtl/tdm_serial_engine_chk.sv
module tdm_serial_engine_chk #(
    parameter int MAX_SLOTS = 8,
    localparam int SW = $clog2(MAX_SLOTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 enable,
    input logic                 sd_oe,
    input logic                 rx_valid,
    input logic                 link_active,
    input logic                 halted,
    input logic                 err_missed,
    input logic                 err_extra,
    input logic [SW-1:0]        cur_slot,
    input logic [2:0]           cur_bit,
    input logic                 cur_extra,
    input logic [MAX_SLOTS-1:0] tx_mask
);
    // R5: the driver only switches on inside a masked, non-extra slot
    a_r5_oe_in_masked_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_oe) |-> (tx_mask[cur_slot] && !cur_extra && link_active));

    // R8: one strobe per assembled byte
    a_r8_rx_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R10: a missed sync halts at the frame start position
    a_r10_missed_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(err_missed) |-> (halted && cur_slot == '0 && cur_bit == 3'd0 && !cur_extra));

    // R11: an extra sync halts away from the frame start
    a_r11_extra_off_start: assert property (@(posedge clk) disable iff (rst)
        $rose(err_extra) |-> (halted && !(cur_slot == '0 && cur_bit == 3'd0 && !cur_extra)));

    // R12: a halted engine is silent
    a_r12_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!sd_oe && !rx_valid && !link_active));

    // R12: the position stays frozen while halted
    a_r12_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> ($stable(cur_slot) && $stable(cur_bit) && $stable(cur_extra)));

    // R13: disabling releases the pins
    a_r13_disable_release: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!link_active && !sd_oe));
endmodule

bind tdm_serial_engine tdm_serial_engine_chk #(.MAX_SLOTS(MAX_SLOTS)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .sd_oe(sd_oe), .rx_valid(rx_valid),
    .link_active(link_active), .halted(halted), .err_missed(err_missed),
    .err_extra(err_extra), .cur_slot(cur_slot), .cur_bit(cur_bit),
    .cur_extra(cur_extra), .tx_mask(tx_mask)
);

// File: tb/test_tdm_serial_engine.sv
`timescale 1ns/1ps
module test_tdm_serial_engine;
    localparam int MAX_SLOTS = 8;
    localparam int SW = 3;
    localparam int CW = 16;
    localparam int P = 8;      // engine cycles per bit period
    localparam int HALF = 4;
    localparam int NS = 3;     // slots per frame used by the bench

    logic clk = 1'b0, rst = 1'b1;
    logic enable = 1'b0, lsb_first = 1'b0, sync_sel = 1'b0, extra_bit = 1'b0;
    logic [SW:0] num_slots = 4'(NS);
    logic [CW-1:0] samp_pt = '0, drv_stop = '0;
    logic [MAX_SLOTS-1:0] tx_mask = '0;
    logic bclk = 1'b0, fsync0 = 1'b0, fsync1 = 1'b0, sd_in = 1'b0;
    logic [7:0] tx_data = '0;
    logic sd_out, sd_oe, link_active, tx_take, rx_valid, halted, err_missed, err_extra, cur_extra;
    logic [7:0] rx_data;
    logic [SW-1:0] rx_slot, cur_slot;
    logic [2:0] cur_bit;

    int n_chk = 0, n_fail = 0, rx_seen = 0;

    always #2.5 clk = ~clk;

    tdm_serial_engine #(.MAX_SLOTS(MAX_SLOTS), .CW(CW)) i_tdm_serial_engine (
        .clk(clk), .rst(rst), .enable(enable), .lsb_first(lsb_first), .sync_sel(sync_sel),
        .num_slots(num_slots), .extra_bit(extra_bit), .samp_pt(samp_pt), .drv_stop(drv_stop),
        .tx_mask(tx_mask), .bclk(bclk), .fsync0(fsync0), .fsync1(fsync1), .sd_in(sd_in),
        .tx_data(tx_data), .sd_out(sd_out), .sd_oe(sd_oe), .link_active(link_active),
        .tx_take(tx_take), .rx_valid(rx_valid), .rx_data(rx_data), .rx_slot(rx_slot),
        .halted(halted), .err_missed(err_missed), .err_extra(err_extra),
        .cur_slot(cur_slot), .cur_bit(cur_bit), .cur_extra(cur_extra)
    );

    always @(negedge clk) if (rx_valid) rx_seen++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] tx_pat(input int s, input int f);
        return 8'hA5 ^ 8'(s * 37 + f * 11);
    endfunction
    function automatic logic [7:0] rx_pat(input int s, input int f);
        return 8'h3C ^ 8'(s * 53 + f * 7 + 1);
    endfunction
    function automatic logic sel_bit(input logic [7:0] b, input int i, input logic lsb);
        return lsb ? b[i] : b[7 - i];
    endfunction

    // One bit period; the selected sync line gets fs_val, the other its inverse.
    task automatic do_bit(input logic fs_val, input bit chk_en, input int s, input int b,
                          input bit x, input int f);
        logic dv, drv, nxt, exp_oe;
        dv  = x ? 1'b0 : sel_bit(rx_pat(s, f), b, lsb_first);
        drv = tx_mask[s] && !x;
        if (b != 7 || x) nxt = 1'b1;
        else if (s == NS - 1) nxt = extra_bit ? 1'b0 : tx_mask[0];
        else nxt = tx_mask[s + 1];
        for (int j = 0; j < P; j++) begin
            @(negedge clk);
            if (j == 0) begin
                bclk = 1'b1;
                fsync0 = sync_sel ? ~fs_val : fs_val;
                fsync1 = sync_sel ? fs_val : ~fs_val;
                tx_data = tx_pat(s, f);
            end
            if (j == HALF) bclk = 1'b0;
            sd_in = (j == int'(samp_pt) + 1) ? dv : ~dv;
            if (chk_en) begin
                if (j == 1) begin
                    chk(cur_slot == SW'(s), "R3 slot", cur_slot, s);
                    chk(cur_bit == 3'(b) || x, "R3 bit", cur_bit, b);
                    chk(cur_extra == x, "R3 extra", cur_extra, x);
                end
                if (j == 2) chk(tx_take == (drv && b == 0), "R4 tx_take", tx_take, drv && b == 0);
                if (j == int'(samp_pt) + 2) begin
                    chk(rx_valid == (b == 7 && !x), "R7 rx_valid timing", rx_valid, b == 7 && !x);
                    if (b == 7 && !x) begin
                        chk(rx_data == rx_pat(s, f), "R8 rx_data", rx_data, rx_pat(s, f));
                        chk(rx_slot == SW'(s), "R8 rx_slot", rx_slot, s);
                    end
                end
                if (j >= 2) begin
                    exp_oe = drv;
                    if (drv && b == 7 && !nxt) exp_oe = (j <= int'(drv_stop) + 1);
                    chk(sd_oe == exp_oe, (drv && b == 7) ? "R6 drive release" : "R5 mask",
                        sd_oe, exp_oe);
                    if (exp_oe)
                        chk(sd_out == sel_bit(tx_pat(s, f), b, lsb_first), "R4 sd_out",
                            sd_out, sel_bit(tx_pat(s, f), b, lsb_first));
                end
            end
        end
    endtask

    task automatic start_link();
        enable = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) do_bit(1'b0, 1'b0, NS - 1, 7, 1'b1, 0);
        chk(sd_oe == 1'b0 && link_active == 1'b1, "R2 hunting", {link_active, sd_oe}, 2);
    endtask

    task automatic run_frame(input int f);
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < 8; b++)
                do_bit(s == 0 && b == 0, 1'b1, s, b, 1'b0, f);
        if (extra_bit) do_bit(1'b0, 1'b1, NS - 1, 0, 1'b1, f);
    endtask

    task automatic stop_link();
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(link_active == 1'b0 && sd_oe == 1'b0, "R13 release", {link_active, sd_oe}, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int seen;
        logic [2:0] masks [6];
        int samps [3];
        int stops [3];
        masks = '{3'b101, 3'b011, 3'b110, 3'b111, 3'b000, 3'b001};
        samps = '{0, 2, 5};
        stops = '{0, 2, 5};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({link_active, sd_oe, halted, err_missed, err_extra, rx_valid} == 6'b0,
            "R1 reset", {link_active, sd_oe, halted, err_missed, err_extra, rx_valid}, 0);

        // Sweep of bit order, extra bit, sample point, drive release, masks, sync select
        for (int cfg = 0; cfg < 36; cfg++) begin
            lsb_first = cfg[0];
            extra_bit = cfg[1];
            samp_pt   = CW'(samps[(cfg / 4) % 3]);
            drv_stop  = CW'(stops[(cfg / 12) % 3]);
            tx_mask   = {5'b0, masks[cfg % 6]};
            sync_sel  = cfg[2] ^ cfg[3];   // R9: both lines exercised
            start_link();
            run_frame(0);
            run_frame(1);
            stop_link();
        end

        // R10 missed sync
        lsb_first = 1'b0; extra_bit = 1'b0; samp_pt = 2; drv_stop = 3;
        tx_mask = 8'b111; sync_sel = 1'b1;
        start_link();
        run_frame(0);
        do_bit(1'b0, 1'b0, 0, 0, 1'b0, 1);
        chk(halted && err_missed && !err_extra, "R10 missed flags", {halted, err_missed, err_extra}, 6);
        chk(cur_slot == 0 && cur_bit == 0 && !cur_extra, "R10 frozen position",
            {cur_slot, cur_bit, cur_extra}, 0);
        chk(!sd_oe && !link_active, "R12 pins released", {sd_oe, link_active}, 0);
        seen = rx_seen;
        do_bit(1'b1, 1'b0, 0, 0, 1'b0, 1);
        do_bit(1'b0, 1'b0, 0, 1, 1'b0, 1);
        chk(cur_slot == 0 && cur_bit == 0, "R12 position frozen", {cur_slot, cur_bit}, 0);
        chk(rx_seen == seen, "R12 no receive while halted", rx_seen, seen);
        chk(halted && err_missed, "R12 halt held", {halted, err_missed}, 3);
        stop_link();
        chk(!halted, "R12 cleared by disable", halted, 0);

        // R11 extra sync at slot 1 bit 3, on line 0
        sync_sel = 1'b0; extra_bit = 1'b1; tx_mask = 8'b010;
        start_link();
        chk(!err_missed && !err_extra, "R11 flags cleared on restart", {err_missed, err_extra}, 0);
        run_frame(0);
        for (int b = 0; b < 8; b++) do_bit(b == 0, 1'b1, 0, b, 1'b0, 1);
        for (int b = 0; b < 3; b++) do_bit(1'b0, 1'b1, 1, b, 1'b0, 1);
        do_bit(1'b1, 1'b0, 1, 3, 1'b0, 1);
        chk(halted && err_extra && !err_missed, "R11 extra flags", {halted, err_missed, err_extra}, 5);
        chk(cur_slot == 1 && cur_bit == 3, "R11 frozen position", {cur_slot, cur_bit}, {3'd1, 3'd3});
        chk(!sd_oe, "R12 driver off after extra sync", sd_oe, 0);
        stop_link();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule